// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port with Cascaded Clock Divider

This block is a 16-bit full-duplex synchronous serial port that can act either as the clock-owning side of a link or as the clock-following side. Software sees one data word location: a write places a word into a transmit holding register, and a read returns the contents of a separate receive holding register. When the shift register is free, a queued transmit word is moved into it automatically and shifted out most significant bit first while the incoming line is shifted in. At the end of the word the captured value lands in the receive holding register.

In the clock-owning role the shift clock is made from the system clock by a coarse divider (1, 4, 16 or 64) followed by a fine divider (1 to 8), so one half period of the shift clock lasts the product of the two ratios in system clock cycles. In the following role the shift clock and the active-low select line come in through a two-stage synchroniser, and edges are detected in the system clock domain. Idle clock level and sampling edge are both selectable, giving all four usual clock modes.

Top module: `spi_port`

## Requirements
- R1: While `en` is low (including after reset) `tx_full`, `rx_full` and `overflow` are 0, `sck_oe` and `sdo_oe` are 0, and `sck_out` rests at the level of `cpol`.
- R2: A write with `tx_full` low stores `wr_data` and sets `tx_full` on the next clock; a write while `tx_full` is high is dropped and its word is never shifted out.
- R3: When the shift register is free, a queued word is taken one clock after it was written: `tx_full` falls and the transfer begins.
- R4: In the clock-owning role each half period of `sck_out` lasts P x S system clocks, where `pri_sel` 0, 1, 2, 3 gives P = 1, 4, 16, 64 and S = `sec_sel` + 1.
- R5: In the clock-owning role one transfer produces exactly 16 clock periods, sends the transmit word MSB first on `sdo`, samples `sdi` on the leading edge when `cpha` is 0 and on the trailing edge when `cpha` is 1 (leading = departure from the `cpol` level), and leaves `sck_out` at the `cpol` level.
- R6: After the 16th bit the received word appears on `rd_data` and `rx_full` rises; a pulse on `rd_en` clears `rx_full`.
- R7: If a word completes while `rx_full` is still high, `overflow` is set, the new word is discarded and `rd_data` keeps the older word; `overflow` is cleared only by dropping `en`.
- R8: In the following role, with `ss_n_in` low, the block shifts on the synchronised `sck_in` edges in all four clock modes, drives `sdo_oe` high, and delivers the master's word to `rd_data` while sending its own word MSB first.
- R9: In the following role, while `ss_n_in` is high, `sdo_oe` is low, `sck_in` edges are ignored and the bit count returns to zero; a word cut short this way is neither delivered nor lost, and the next frame sends the queued word again from its first bit.
- R10: Dropping `en` for one cycle clears `overflow` and both full flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds everything idle |
| master | input | 1 | 1 = block generates the shift clock, 0 = follows `sck_in` |
| cpol | input | 1 | Idle level of the shift clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| pri_sel | input | 2 | Coarse divider select (1, 4, 16, 64) |
| sec_sel | input | 3 | Fine divider select (ratio = value + 1) |
| wr_en | input | 1 | Write strobe for the data word |
| wr_data | input | 16 | Word to transmit |
| rd_en | input | 1 | Read strobe; clears `rx_full` |
| rd_data | output | 16 | Receive holding register |
| tx_full | output | 1 | Transmit holding register occupied |
| rx_full | output | 1 | Receive holding register unread |
| overflow | output | 1 | A completed word was lost |
| sck_in | input | 1 | Shift clock from the line (following role) |
| ss_n_in | input | 1 | Active-low select (following role) |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
The bench acts as the far end of the link in both roles, so an off-by-one in the bit order, a swapped sampling edge for one of the four modes, or a half period that counts P + S instead of P x S shows up as a wrong captured word or a wrong toggle spacing. A second write issued while the first is still queued must not start a second transfer; a design that overwrote the holding register would send the wrong word or send twice. A completion against an unread receive register must keep the old word and raise the loss flag, which a design writing through would miss. A select line released mid-word must throw the partial bits away and restart from the first bit; a design that kept its bit count would deliver a misaligned word on the next frame.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_fmt_t;

  // Coarse divider ratio: four raised to the select value.
  function automatic int unsigned pri_ratio(input int unsigned sel);
    return 32'd1 << (2 * sel);
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_prescaler.sv
module spi_prescaler #(
  parameter int PRI_W = 2,
  parameter int SEC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRI_W-1:0] pri_sel,
  input  logic [SEC_W-1:0] sec_sel,
  output logic             tick
);

  localparam int PCNT_W = 2 * ((1 << PRI_W) - 1);

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] plim;
  logic [SEC_W-1:0]  scnt;
  logic              pri_hit;

  always_comb begin
    plim    = PCNT_W'(spi_pkg::pri_ratio(int'(pri_sel)) - 32'd1);
    pri_hit = (pcnt == plim);
    tick    = run && pri_hit && (scnt == sec_sel);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      scnt <= '0;
    end else begin
      pcnt <= pri_hit ? '0 : pcnt + 1'b1;
      if (pri_hit) scnt <= (scnt == sec_sel) ? '0 : scnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              master,
  input  spi_pkg::spi_fmt_t fmt,
  input  logic              tick,
  input  logic              sck_s,
  input  logic              ss_s,
  input  logic              sdi,
  input  logic              load,
  input  logic [W-1:0]      load_data,
  output logic              idle,
  output logic              run,
  output logic              done,
  output logic [W-1:0]      rx_word,
  output logic              sck_o,
  output logic              sdo_o
);

  localparam int CNT_W = $clog2(W);

  logic             busy;
  logic [W-1:0]     sh;
  logic [W-1:0]     save;
  logic [CNT_W-1:0] cnt;
  logic             sck_r;
  logic             sck_d;
  logic             sdo_r;

  logic lead, trail, samp, drv, s_chg;
  logic [W-1:0] sh_next;

  always_comb begin
    s_chg = (sck_s != sck_d);
    if (master) begin
      lead  = tick && (sck_r == fmt.cpol);
      trail = tick && (sck_r != fmt.cpol);
    end else begin
      lead  = !ss_s && s_chg && (sck_s != fmt.cpol);
      trail = !ss_s && s_chg && (sck_s == fmt.cpol);
    end
    samp    = fmt.cpha ? trail : lead;
    drv     = fmt.cpha ? lead : trail;
    sh_next = samp ? {sh[W-2:0], sdi} : sh;
    done    = trail && (cnt == CNT_W'(W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy  <= 1'b0;
      sh    <= '0;
      save  <= '0;
      cnt   <= '0;
      sck_r <= fmt.cpol;
      sck_d <= sck_s;
      sdo_r <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (load) begin
        sh    <= load_data;
        save  <= load_data;
        sdo_r <= load_data[W-1];
        cnt   <= '0;
        busy  <= master;
        sck_r <= fmt.cpol;
      end else if (!master && ss_s) begin
        cnt   <= '0;
        busy  <= 1'b0;
        sh    <= save;
        sdo_r <= save[W-1];
      end else begin
        sh <= sh_next;
        if (drv) sdo_r <= sh_next[W-1];
        if (lead || trail) busy <= 1'b1;
        if (trail) cnt <= done ? '0 : cnt + 1'b1;
        if (done) busy <= 1'b0;
        if (master) begin
          if (tick) sck_r <= ~sck_r;
          else if (!busy) sck_r <= fmt.cpol;
        end
      end
    end
  end

  assign idle    = !busy;
  assign run     = busy && master;
  assign rx_word = sh_next;
  assign sck_o   = sck_r;
  assign sdo_o   = sdo_r;

endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W = 16,
  parameter int PRI_W = 2,
  parameter int SEC_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             master,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [PRI_W-1:0] pri_sel,
  input  logic [SEC_W-1:0] sec_sel,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic             tx_full,
  output logic             rx_full,
  output logic             overflow,
  input  logic             sck_in,
  input  logic             ss_n_in,
  input  logic             sdi,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             sdo,
  output logic             sdo_oe
);

  spi_pkg::spi_fmt_t fmt;
  logic [1:0]   line_s;
  logic         sck_s, ss_s;
  logic         tick, run, idle, done, load;
  logic [W-1:0] tx_buf;
  logic [W-1:0] rx_word;

  assign fmt.cpol = cpol;
  assign fmt.cpha = cpha;

  spi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_in, ss_n_in}),
    .q   (line_s)
  );
  assign sck_s = line_s[1];
  assign ss_s  = line_s[0];

  spi_prescaler #(.PRI_W(PRI_W), .SEC_W(SEC_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .pri_sel (pri_sel),
    .sec_sel (sec_sel),
    .tick    (tick)
  );

  assign load = en && tx_full && idle;

  spi_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .master    (master),
    .fmt       (fmt),
    .tick      (tick),
    .sck_s     (sck_s),
    .ss_s      (ss_s),
    .sdi       (sdi),
    .load      (load),
    .load_data (tx_buf),
    .idle      (idle),
    .run       (run),
    .done      (done),
    .rx_word   (rx_word),
    .sck_o     (sck_out),
    .sdo_o     (sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf  <= '0;
      rd_data <= '0;
    end else begin
      if (en && !tx_full && wr_en) tx_buf <= wr_data;
      if (en && done && !(rx_full && !rd_en)) rd_data <= rx_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tx_full  <= 1'b0;
      rx_full  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (load) tx_full <= 1'b0;
      else if (wr_en && !tx_full) tx_full <= 1'b1;
      if (done) begin
        if (rx_full && !rd_en) overflow <= 1'b1;
        else rx_full <= 1'b1;
      end else if (rd_en) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sck_oe <= 1'b0;
    else sck_oe <= en && master;
  end

  assign sdo_oe = en && (master || !ss_s);

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic master,
  input logic cpol,
  input logic wr_en,
  input logic rd_en,
  input logic tx_full,
  input logic rx_full,
  input logic overflow,
  input logic ss_n_in,
  input logic sck_out,
  input logic sdo_oe
);

  // R2
  tx_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_full) |-> $past(wr_en));

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |-> ($past(rd_en) || !$past(en)));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(rx_full));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(overflow) |-> !$past(en));

  // R9
  ss_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !master && $past(ss_n_in, 2)) |-> !sdo_oe);

  // R1
  idle_sck_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en) && $stable(cpol)) |-> (sck_out == cpol));

endmodule

bind spi_port spi_port_chk u_chk (.*);

// File: tb/spi_port_tb.sv
`timescale 1ns/100ps
module spi_port_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, master = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [1:0] pri_sel = '0;
  logic [2:0] sec_sel = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic tx_full, rx_full, overflow;
  logic sck_in = 1'b0, ss_n_in = 1'b1;
  logic sck_out, sck_oe, sdo, sdo_oe;
  logic s_sdi = 1'b0, m_sdi = 1'b0;
  wire  sdi = master ? s_sdi : m_sdi;

  int n_chk = 0, n_fail = 0;

  // Far-end model state (bench as clock follower)
  logic [15:0] sw_word, s_cap, m_cap;
  int   idx = 0, tg = 0, per_bad = 0;
  realtime last_t = 0.0, half_ns = 5.0;
  localparam int H = 6;

  always #2.5 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rst(rst), .en(en), .master(master), .cpol(cpol), .cpha(cpha),
    .pri_sel(pri_sel), .sec_sel(sec_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tx_full(tx_full), .rx_full(rx_full),
    .overflow(overflow), .sck_in(sck_in), .ss_n_in(ss_n_in), .sdi(sdi),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(sck_out) begin
    if (master && en) begin
      if (tg > 0 && ($realtime - last_t) != half_ns) per_bad++;
      last_t = $realtime;
      tg++;
      if (sck_out != cpol) begin
        if (!cpha) s_cap = {s_cap[14:0], sdo};
        else begin
          idx++;
          if (idx < 16) s_sdi = sw_word[15-idx];
        end
      end else begin
        if (!cpha) begin
          idx++;
          if (idx < 16) s_sdi = sw_word[15-idx];
        end else s_cap = {s_cap[14:0], sdo};
      end
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic m, input logic pol, input logic pha,
                       input logic [1:0] p, input logic [2:0] s);
    @(negedge clk);
    en = 1'b0;
    master = m; cpol = pol; cpha = pha; pri_sel = p; sec_sel = s;
    sck_in = pol; ss_n_in = 1'b1;
    ticks(3);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic far_init(input logic [15:0] w);
    sw_word = w; s_cap = '0; tg = 0; per_bad = 0;
    half_ns = 5.0 * (4.0 ** pri_sel) * (sec_sel + 1);
    if (cpha) begin idx = -1; s_sdi = 1'b0; end
    else begin idx = 0; s_sdi = w[15]; end
  endtask

  task automatic write_word(input logic [15:0] w);
    wr_data = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 40000 && !rx_full; i++) @(negedge clk);
  endtask

  task automatic read_word();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic master_xfer(input logic pol, input logic pha, input logic [1:0] p,
                             input logic [2:0] s, input logic [15:0] txw,
                             input logic [15:0] fw);
    setup(1'b1, pol, pha, p, s);
    far_init(fw);
    write_word(txw);
    chk(tx_full == 1'b1, "R2 tx_full after write", 32'(tx_full), 1);
    @(negedge clk);
    chk(tx_full == 1'b0, "R3 word taken when idle", 32'(tx_full), 0);
    wait_rx();
    ticks(2);
    chk(rd_data == fw, "R6 received word", 32'(rd_data), 32'(fw));
    chk(s_cap == txw, "R5 transmitted word MSB first", 32'(s_cap), 32'(txw));
    chk(per_bad == 0, "R4 half period P x S", 32'(per_bad), 0);
    chk(tg == 32, "R5 sixteen clock periods", 32'(tg), 32);
    chk(sck_out == pol, "R5 clock idles at cpol", 32'(sck_out), 32'(pol));
    read_word();
    chk(rx_full == 1'b0, "R6 read clears rx_full", 32'(rx_full), 0);
  endtask

  task automatic slave_bits(input logic [15:0] w, input int nb);
    for (int i = 0; i < nb; i++) begin
      if (!cpha) begin
        m_sdi = w[15-i];
        ticks(H);
        m_cap = {m_cap[14:0], sdo};
        sck_in = ~sck_in;
        ticks(H);
        sck_in = ~sck_in;
      end else begin
        sck_in = ~sck_in;
        m_sdi = w[15-i];
        ticks(H);
        m_cap = {m_cap[14:0], sdo};
        sck_in = ~sck_in;
        ticks(H);
      end
    end
  endtask

  task automatic slave_xfer(input logic pol, input logic pha, input logic [15:0] txw,
                            input logic [15:0] mw);
    setup(1'b0, pol, pha, 2'd0, 3'd0);
    write_word(txw);
    ticks(3);
    chk(tx_full == 1'b0, "R3 follower loads queued word", 32'(tx_full), 0);
    m_cap = '0;
    ss_n_in = 1'b0;
    ticks(H);
    chk(sdo_oe == 1'b1, "R8 sdo driven while selected", 32'(sdo_oe), 1);
    slave_bits(mw, 16);
    ticks(H);
    ss_n_in = 1'b1;
    ticks(4);
    chk(rx_full == 1'b1, "R8 follower word complete", 32'(rx_full), 1);
    chk(rd_data == mw, "R8 follower received word", 32'(rd_data), 32'(mw));
    chk(m_cap == txw, "R8 follower sent word", 32'(m_cap), 32'(txw));
    chk(sdo_oe == 1'b0, "R9 sdo released when deselected", 32'(sdo_oe), 0);
    read_word();
  endtask

  initial begin
    ticks(5);
    rst = 1'b0;
    ticks(2);
    // R1 reset / disabled state
    chk({tx_full, rx_full, overflow} == 3'b000, "R1 flags clear", 32'({tx_full, rx_full, overflow}), 0);
    chk({sck_oe, sdo_oe} == 2'b00, "R1 drivers off", 32'({sck_oe, sdo_oe}), 0);
    chk(sck_out == 1'b0, "R1 clock at cpol=0", 32'(sck_out), 0);
    cpol = 1'b1;
    ticks(3);
    chk(sck_out == 1'b1, "R1 clock at cpol=1", 32'(sck_out), 1);

    // Master in all four modes, several divider settings
    master_xfer(1'b0, 1'b0, 2'd0, 3'd0, 16'hA5C3, 16'h3C5A);
    chk(sck_oe == 1'b1, "R5 clock driven as owner", 32'(sck_oe), 1);
    master_xfer(1'b1, 1'b0, 2'd1, 3'd2, 16'h8001, 16'hFFFE);
    master_xfer(1'b0, 1'b1, 2'd2, 3'd0, 16'h1234, 16'hEDCB);
    master_xfer(1'b1, 1'b1, 2'd0, 3'd7, 16'hF00F, 16'h0FF0);
    master_xfer(1'b0, 1'b1, 2'd3, 3'd7, 16'h6B29, 16'h94D6);

    // R2 write while full is dropped
    setup(1'b1, 1'b0, 1'b0, 2'd0, 3'd1);
    far_init(16'h0F0F);
    wr_data = 16'hC001; wr_en = 1'b1;
    @(negedge clk);
    wr_data = 16'hBEEF;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tx_full == 1'b0, "R2 second write dropped", 32'(tx_full), 0);
    wait_rx();
    ticks(40);
    chk(s_cap == 16'hC001, "R2 first word kept", 32'(s_cap), 32'hC001);
    chk(tg == 32, "R2 no second transfer", 32'(tg), 32);
    read_word();

    // R7 overflow
    setup(1'b1, 1'b0, 1'b0, 2'd0, 3'd0);
    far_init(16'h1111);
    write_word(16'h2222);
    wait_rx();
    ticks(2);
    far_init(16'h7777);
    write_word(16'h3333);
    for (int i = 0; i < 2000 && tg < 32; i++) @(negedge clk);
    ticks(4);
    chk(overflow == 1'b1, "R7 overflow set", 32'(overflow), 1);
    chk(rd_data == 16'h1111, "R7 new word discarded", 32'(rd_data), 32'h1111);
    chk(rx_full == 1'b1, "R7 rx stays full", 32'(rx_full), 1);
    read_word();
    chk(rx_full == 1'b0, "R6 read clears rx_full", 32'(rx_full), 0);
    chk(overflow == 1'b1, "R7 overflow sticky on read", 32'(overflow), 1);
    en = 1'b0;
    @(negedge clk);
    chk(overflow == 1'b0, "R10 disable clears overflow", 32'(overflow), 0);
    en = 1'b1;
    @(negedge clk);

    // Follower role in all four modes
    slave_xfer(1'b0, 1'b0, 16'hA55A, 16'h5AA5);
    slave_xfer(1'b1, 1'b0, 16'h8421, 16'h1248);
    slave_xfer(1'b0, 1'b1, 16'hCAFE, 16'h0D15);
    slave_xfer(1'b1, 1'b1, 16'h7E81, 16'h9119);

    // R9 select released mid-word
    setup(1'b0, 1'b0, 1'b0, 2'd0, 3'd0);
    write_word(16'hD00D);
    ticks(3);
    m_cap = '0;
    ss_n_in = 1'b0;
    ticks(H);
    slave_bits(16'hFFFF, 5);
    ticks(H);
    ss_n_in = 1'b1;
    ticks(6);
    chk(rx_full == 1'b0, "R9 partial word dropped", 32'(rx_full), 0);
    for (int i = 0; i < 4; i++) begin
      sck_in = ~sck_in;
      ticks(H);
    end
    chk(rx_full == 1'b0, "R9 edges ignored while deselected", 32'(rx_full), 0);
    m_cap = '0;
    ss_n_in = 1'b0;
    ticks(H);
    slave_bits(16'h4C3B, 16);
    ticks(H);
    ss_n_in = 1'b1;
    ticks(4);
    chk(m_cap == 16'hD00D, "R9 word restarts from first bit", 32'(m_cap), 32'hD00D);
    chk(rd_data == 16'h4C3B, "R9 bit count reset", 32'(rd_data), 32'h4C3B);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule